// File: doc/BRIEF.md
# Dual-Mode Motor PWM Channel

This block is one channel of a motor-control PWM generator. A 16-bit counter advances once per tick of a power-of-two prescaler. It either counts up and wraps, which gives edge-aligned pulses, or sweeps up and then back down, which gives center-aligned pulses. Two compare values are checked against the counter. Each result drives one of the two outputs, a high-side output and a low-side output, and each output can be enabled and inverted on its own.

The configuration inputs are static levels that the surrounding register file holds. These are the prescale exponent, the counting mode, the period, the two compare values, the timer and PWM enables, and the output enable and invert bits. A one-cycle load strobe writes a new counter value. Software uses it to restart the waveform from zero when it changes the duty. To get a complementary pair, set both compares to the same value and invert only the low-side output.

Top module: `pwmc_channel`

## Requirements
- R1: After reset the counter reads 0 and both outputs are low.
- R2: With mode 2'b01 the counter steps 0, 1, ..., PERIOD on each tick and then returns to 0, so one cycle lasts PERIOD+1 ticks.
- R3: With mode 2'b10 the counter climbs to PERIOD, holds that value for one extra tick, descends to 0 and holds 0 for one extra tick, so one cycle lasts 2*(PERIOD+1) ticks.
- R4: With mode 2'b00 (or 2'b11) the counter holds its value while the timer is enabled.
- R5: With prescale exponent N, the counter advances once every 2^N clock cycles. The count starts from the cycle after a load.
- R6: Before enable and inversion, the high-side output is 1 exactly when the counter is below the high compare value. The low-side output is 1 exactly when the counter is below the low compare value.
- R7: Each invert bit flips its own output only. With equal compare values and only the low-side output inverted, the two outputs are complementary.
- R8: An output whose own enable is 0 is low whatever its invert bit. When the PWM enable is 0, both outputs are low.
- R9: When the timer enable is 0, the counter and the prescaler phase hold.
- R10: A load strobe sets the counter to the load value on the next cycle. It restarts the prescaler phase, and counting then resumes in the upward direction.
- R11: A compare value of 0 holds a non-inverted output low. A compare value above PERIOD holds it high in mode 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_en | input | 1 | Timer enable |
| pwm_en | input | 1 | PWM output enable for the whole channel |
| ps_sel | input | 4 | Prescale exponent N; tick every 2^N clocks |
| cnt_mode | input | 2 | 00 stop, 01 edge-aligned, 10 center-aligned |
| period | input | 16 | Counter top value |
| cmp_hi | input | 16 | High-side compare value |
| cmp_lo | input | 16 | Low-side compare value |
| hi_en | input | 1 | High-side output enable |
| lo_en | input | 1 | Low-side output enable |
| hi_inv | input | 1 | High-side invert |
| lo_inv | input | 1 | Low-side invert |
| cnt_load | input | 1 | Counter load strobe |
| cnt_load_val | input | 16 | Value written by the load strobe |
| count | output | 16 | Current counter value |
| out_hi | output | 1 | High-side PWM output |
| out_lo | output | 1 | Low-side PWM output |

## Verification
The bench checks the turning points of the center sweep. A design that leaves out the repeated count at PERIOD or at 0 would drift against the expected sequence within one cycle. It also checks the edge-mode wrap, where an off-by-one gives PERIOD or PERIOD+2 ticks per cycle. The prescaler phase after a load is followed through many ticks, so a divider that ticks one clock early or late fails at once. The bench loads the counter while it is counting down, which catches a direction bit that is not reset. Compares of 0 and above PERIOD are driven as well, together with inverted but disabled outputs, to catch an inversion applied after the enable gate.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    typedef enum logic [1:0] {
        MODE_STOP   = 2'b00,
        MODE_EDGE   = 2'b01,
        MODE_CENTER = 2'b10,
        MODE_RSVD   = 2'b11
    } cnt_mode_e;

endpackage

// File: rtl/pwmc_prescaler.sv
module pwmc_prescaler #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            restart_i,
    input  logic [PS_W-1:0] sel_i,
    output logic            tick_o
);
    localparam int DIV_W = (1 << PS_W) - 1;

    typedef struct packed {
        logic [DIV_W-1:0] phase;
    } ps_state_t;

    ps_state_t st_d, st_q;
    logic [DIV_W-1:0] limit;

    // limit = 2^N - 1: N low-order ones
    assign limit  = ~({DIV_W{1'b1}} << sel_i);
    assign tick_o = en_i && !restart_i && (st_q.phase == limit);

    always_comb begin
        st_d = st_q;
        if (restart_i) begin
            st_d.phase = '0;
        end else if (en_i) begin
            if (st_q.phase == limit) st_d.phase = '0;
            else                     st_d.phase = st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && sel_i != '0) |=> (!tick_o || sel_i != $past(sel_i) || restart_i)) else $error("prescaler ticked twice in a row"); // R5

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !restart_i) |=> !tick_o || sel_i != $past(sel_i) || st_q.phase == $past(st_q.phase)) else $error("prescaler phase moved while disabled"); // R9

endmodule

// File: rtl/pwmc_timer.sv
module pwmc_timer
    import pwmc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    cnt_mode_e  mode;

    assign mode  = cnt_mode_e'(mode_i);
    assign cnt_o = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cnt  = load_val_i;
            st_d.down = 1'b0;
        end else if (tick_i) begin
            case (mode)
                MODE_EDGE: begin
                    st_d.down = 1'b0;
                    if (st_q.cnt >= period_i) st_d.cnt = '0;
                    else                      st_d.cnt = st_q.cnt + 1'b1;
                end
                MODE_CENTER: begin
                    if (!st_q.down) begin
                        // turning point at the top: count repeats once
                        if (st_q.cnt >= period_i) st_d.down = 1'b1;
                        else                      st_d.cnt  = st_q.cnt + 1'b1;
                    end else begin
                        // turning point at zero: count repeats once
                        if (st_q.cnt == '0) st_d.down = 1'b0;
                        else                st_d.cnt  = st_q.cnt - 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && mode_i == 2'b01 && st_q.cnt >= period_i) |=> (st_q.cnt == '0)) else $error("edge wrap missed"); // R2

    AST_CENTER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && mode_i == 2'b10 && !st_q.down && st_q.cnt >= period_i) |=> (st_q.down && $stable(st_q.cnt))) else $error("center top turn wrong"); // R3

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (mode_i == 2'b00 || mode_i == 2'b11)) |=> $stable(st_q.cnt)) else $error("stopped counter moved"); // R4

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(st_q.cnt)) else $error("counter moved without a tick"); // R9

    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (st_q.cnt == $past(load_val_i) && !st_q.down)) else $error("load not taken"); // R10

endmodule

// File: rtl/pwmc_shaper.sv
module pwmc_shaper #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_hi_i,
    input  logic [CNT_W-1:0] cmp_lo_i,
    input  logic             pwm_en_i,
    input  logic             hi_en_i,
    input  logic             lo_en_i,
    input  logic             hi_inv_i,
    input  logic             lo_inv_i,
    output logic             out_hi_o,
    output logic             out_lo_o
);
    localparam int NSIDE = 2;

    logic [NSIDE-1:0]            en_v, inv_v, raw_v, out_v;
    logic [NSIDE-1:0][CNT_W-1:0] cmp_v;

    assign cmp_v = {cmp_lo_i, cmp_hi_i};
    assign en_v  = {lo_en_i, hi_en_i};
    assign inv_v = {lo_inv_i, hi_inv_i};

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        always_comb begin
            raw_v[s] = (cnt_i < cmp_v[s]);
            out_v[s] = pwm_en_i && en_v[s] && (raw_v[s] ^ inv_v[s]);
        end
    end

    assign out_hi_o = out_v[0];
    assign out_lo_o = out_v[1];

    AST_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en_i && hi_en_i && lo_en_i && !hi_inv_i && lo_inv_i && cmp_hi_i == cmp_lo_i) |-> (out_hi_o != out_lo_o)) else $error("pair not complementary"); // R7

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_en_i) |-> (!out_hi_o && !out_lo_o)) else $error("output active while PWM disabled"); // R8

endmodule

// File: rtl/pwmc_channel.sv
module pwmc_channel #(
    parameter int CNT_W = 16,
    parameter int PS_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic             pwm_en,
    input  logic [PS_W-1:0]  ps_sel,
    input  logic [1:0]       cnt_mode,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_hi,
    input  logic [CNT_W-1:0] cmp_lo,
    input  logic             hi_en,
    input  logic             lo_en,
    input  logic             hi_inv,
    input  logic             lo_inv,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_load_val,
    output logic [CNT_W-1:0] count,
    output logic             out_hi,
    output logic             out_lo
);
    logic tick;

    pwmc_prescaler #(.PS_W(PS_W)) u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (tmr_en),
        .restart_i(cnt_load),
        .sel_i    (ps_sel),
        .tick_o   (tick)
    );

    pwmc_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .load_i    (cnt_load),
        .load_val_i(cnt_load_val),
        .mode_i    (cnt_mode),
        .period_i  (period),
        .cnt_o     (count)
    );

    pwmc_shaper #(.CNT_W(CNT_W)) u_shp (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (count),
        .cmp_hi_i(cmp_hi),
        .cmp_lo_i(cmp_lo),
        .pwm_en_i(pwm_en),
        .hi_en_i (hi_en),
        .lo_en_i (lo_en),
        .hi_inv_i(hi_inv),
        .lo_inv_i(lo_inv),
        .out_hi_o(out_hi),
        .out_lo_o(out_lo)
    );

    AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (count == '0)) else $error("counter not zero after reset"); // R1

endmodule

// File: tb/sim_pwmc_channel.sv
module sim_pwmc_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_en = 1'b0, pwm_en = 1'b0;
    logic [3:0]  ps_sel = '0;
    logic [1:0]  cnt_mode = 2'b00;
    logic [15:0] period = '0, cmp_hi = '0, cmp_lo = '0;
    logic        hi_en = 1'b0, lo_en = 1'b0, hi_inv = 1'b0, lo_inv = 1'b0;
    logic        cnt_load = 1'b0;
    logic [15:0] cnt_load_val = '0;
    logic [15:0] count;
    logic        out_hi, out_lo;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    pwmc_channel u0 (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .pwm_en(pwm_en),
        .ps_sel(ps_sel), .cnt_mode(cnt_mode), .period(period),
        .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .hi_en(hi_en), .lo_en(lo_en),
        .hi_inv(hi_inv), .lo_inv(lo_inv), .cnt_load(cnt_load),
        .cnt_load_val(cnt_load_val), .count(count), .out_hi(out_hi), .out_lo(out_lo)
    );

    task automatic chk(input int act, input int exp, input string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // strobe a load; returns on the negedge where the loaded value is visible
    task automatic load_cnt(input int v);
        @(negedge clk);
        cnt_load = 1'b1;
        cnt_load_val = 16'(v);
        @(negedge clk);
        cnt_load = 1'b0;
    endtask

    function automatic int center_pos(input int k, input int p);
        int m = k % (2 * p + 2);
        return (m <= p) ? m : (2 * p + 1 - m);
    endfunction

    task automatic t_reset;
        chk(int'(count), 0, "R1 count");
        chk(int'(out_hi), 0, "R1 out_hi");
        chk(int'(out_lo), 0, "R1 out_lo");
    endtask

    task automatic t_edge;
        ps_sel = 0; cnt_mode = 2'b01; period = 4; tmr_en = 1;
        load_cnt(0);
        chk(int'(count), 0, "R2 start");
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            chk(int'(count), k % 5, "R2 edge sequence");
        end
    endtask

    task automatic t_center;
        ps_sel = 0; cnt_mode = 2'b10; period = 3; tmr_en = 1;
        load_cnt(0);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            chk(int'(count), center_pos(k, 3), "R3 center sweep");
        end
    endtask

    task automatic t_prescale;
        ps_sel = 2; cnt_mode = 2'b01; period = 5; tmr_en = 1;
        load_cnt(0);
        for (int j = 1; j <= 40; j++) begin
            @(negedge clk);
            chk(int'(count), (j / 4) % 6, "R5 prescale by 4");
        end
        ps_sel = 0;
    endtask

    task automatic t_stop_mode;
        int v;
        cnt_mode = 2'b01; period = 9; tmr_en = 1;
        load_cnt(3);
        cnt_mode = 2'b00;
        @(negedge clk);
        v = int'(count);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(int'(count), v, "R4 stop mode holds");
        end
    endtask

    task automatic t_tmr_off;
        int v;
        cnt_mode = 2'b01; period = 9; tmr_en = 1;
        load_cnt(0);
        repeat (3) @(negedge clk);
        tmr_en = 0;
        @(negedge clk);
        v = int'(count);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(int'(count), v, "R9 timer disabled holds");
        end
        tmr_en = 1;
        @(negedge clk);
        chk(int'(count), (v + 1) % 10, "R9 resume");
    endtask

    task automatic t_compare;
        cnt_mode = 2'b01; period = 9; tmr_en = 1; pwm_en = 1;
        hi_en = 1; lo_en = 1;
        // complementary pair
        cmp_hi = 4; cmp_lo = 4; hi_inv = 0; lo_inv = 1;
        load_cnt(0);
        for (int k = 0; k < 20; k++) begin
            chk(int'(out_hi), int'((k % 10) < 4), "R6 hi compare");
            chk(int'(out_lo), int'(!((k % 10) < 4)), "R7 lo complement");
            @(negedge clk);
        end
        // independent compares, no inversion
        cmp_hi = 7; cmp_lo = 2; lo_inv = 0;
        load_cnt(0);
        for (int k = 0; k < 10; k++) begin
            chk(int'(out_hi), int'(k < 7), "R6 hi cmp 7");
            chk(int'(out_lo), int'(k < 2), "R6 lo cmp 2");
            @(negedge clk);
        end
        // invert high only
        cmp_hi = 4; cmp_lo = 4; hi_inv = 1;
        load_cnt(0);
        for (int k = 0; k < 10; k++) begin
            chk(int'(out_hi), int'(!(k < 4)), "R7 hi inverted");
            chk(int'(out_lo), int'(k < 4), "R7 lo untouched");
            @(negedge clk);
        end
        hi_inv = 0;
    endtask

    task automatic t_extremes;
        cnt_mode = 2'b01; period = 9; tmr_en = 1; pwm_en = 1;
        hi_en = 1; lo_en = 1; hi_inv = 0; lo_inv = 0;
        cmp_hi = 0; cmp_lo = 10;
        load_cnt(0);
        for (int k = 0; k < 12; k++) begin
            chk(int'(out_hi), 0, "R11 cmp 0 low");
            chk(int'(out_lo), 1, "R11 cmp above period high");
            @(negedge clk);
        end
    endtask

    task automatic t_disable;
        cnt_mode = 2'b01; period = 9; tmr_en = 1; pwm_en = 1;
        cmp_hi = 5; cmp_lo = 5; hi_en = 0; lo_en = 1; hi_inv = 1; lo_inv = 0;
        load_cnt(0);
        for (int k = 0; k < 10; k++) begin
            chk(int'(out_hi), 0, "R8 hi disabled");
            chk(int'(out_lo), int'(k < 5), "R8 lo still enabled");
            @(negedge clk);
        end
        hi_en = 1; lo_inv = 1; pwm_en = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(int'(out_hi), 0, "R8 pwm off hi");
            chk(int'(out_lo), 0, "R8 pwm off lo");
        end
        pwm_en = 1; hi_inv = 0; lo_inv = 0;
    endtask

    task automatic t_load_center;
        cnt_mode = 2'b10; period = 9; tmr_en = 1; ps_sel = 0;
        load_cnt(0);
        repeat (12) @(negedge clk);
        chk(int'(count), center_pos(12, 9), "R3 descending before load");
        load_cnt(5);
        chk(int'(count), 5, "R10 load value");
        @(negedge clk);
        chk(int'(count), 6, "R10 direction up after load");
        load_cnt(7);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            chk(int'(count), center_pos(7 + k, 9), "R10 sweep from loaded value");
        end
        // prescaler phase restarts on load
        ps_sel = 1; cnt_mode = 2'b01;
        load_cnt(2);
        @(negedge clk);
        chk(int'(count), 2, "R10 phase restart wait");
        @(negedge clk);
        chk(int'(count), 3, "R10 phase restart tick");
        ps_sel = 0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_center();
        t_prescale();
        t_stop_mode();
        t_tmr_off();
        t_compare();
        t_extremes();
        t_disable();
        t_load_center();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule